// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block derives the clock waveform for an I2C master from the functional clock. A prescaler divides the functional clock by (prescale + 1) to make an internal sampling tick. Two phase counters then count those ticks: the SCL low phase lasts the programmed low value plus 7 ticks, and the high phase lasts the programmed high value plus 5 ticks. The resulting bit rate is fclk / ((psc+1) * (low + 7 + high + 5)). For example, at 48 MHz with prescale 1, low/high pairs of 111/117, 23/25 and 5/7 give roughly 100 kHz, 400 kHz and 1 MHz.

Each 16-bit timing word holds two 8-bit values. The lower byte is used in standard/fast operation and the upper byte in high-speed operation, chosen by a mode input. The prescale value, both timing values and the mode are captured in a shadow copy. This copy is taken while the block is idle and again at the end of every high phase, so a new setting takes effect at the start of the next low phase and never shortens a phase in progress.

A downstream bit engine uses the tick and the two phase-end strobes. All pins are plain control and status signals. No data flows through the block, so it has no valid/ready handshake. Clock stretching, START/STOP conditions and pad drive are handled elsewhere.

Top module: `scl_rate_gen`

## Requirements
- R1: While enabled, `tick` is high for one cycle in every (psc+1) functional-clock cycles, where psc is the captured prescale value (psc = 0 makes `tick` high every cycle).
- R2: The SCL low phase lasts (low + 7) ticks, which is (low + 7) * (psc + 1) clock cycles.
- R3: The SCL high phase lasts (high + 5) ticks, which is (high + 5) * (psc + 1) clock cycles.
- R4: With `hs_mode` = 0 the low and high values are bits [7:0] of `scl_lo_time` and `scl_hi_time`; with `hs_mode` = 1 they are bits [15:8] of the same words.
- R5: The prescale value, the timing words and `hs_mode` are captured when the block is idle and at the last cycle of each high phase. A change at any other time has no effect on the current low or high phase; the change in the same cycle as `high_end` applies to the very next low phase.
- R6: When `enable` is low, `scl` is 1 and `tick` is 0 from the next cycle on. Once `enable` is sampled high, the next cycle starts a full low phase with the divider restarted.
- R7: `low_end` is high for exactly the last cycle of each low phase, and `high_end` is high for exactly the last cycle of each high phase. Each strobe coincides with `tick`, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the generator; low holds SCL high and restarts counters |
| psc | input | 8 | Prescale value; tick period is psc+1 cycles |
| scl_lo_time | input | 16 | Low-phase values: [7:0] standard/fast, [15:8] high-speed |
| scl_hi_time | input | 16 | High-phase values: [7:0] standard/fast, [15:8] high-speed |
| hs_mode | input | 1 | 1 selects the upper bytes of the timing words |
| tick | output | 1 | Internal sampling tick, one cycle wide |
| scl | output | 1 | Generated SCL level |
| low_end | output | 1 | Strobe in the last cycle of a low phase |
| high_end | output | 1 | Strobe in the last cycle of a high phase |

## Verification
Two events can fall in the same cycle: the capture of a new setting and the final tick of a high phase, marked by `high_end`. The bench changes prescale, timing and mode exactly in the cycle it sees `high_end`. It then checks that the following low phase has the length set by the new values, while the high phase just ending kept the old length. It also changes the settings early in a low phase and expects the new values to appear only after the following high phase. Across random and corner settings (prescale 0, zero timing values, upper-byte selection), expected lengths, tick counts and strobe positions come from bench functions of the requirement formulas.

// File: rtl/scl_pkg.sv
package scl_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} scl_phase_e;

  // Fixed phase extensions, in sampling ticks
  localparam int unsigned LOW_EXT  = 7;
  localparam int unsigned HIGH_EXT = 5;
endpackage

// File: rtl/scl_cfg_shadow.sv
module scl_cfg_shadow #(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned VAL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               reload,
  input  logic [PSC_W-1:0]   psc_in,
  input  logic [2*VAL_W-1:0] lo_word,
  input  logic [2*VAL_W-1:0] hi_word,
  input  logic               hs_sel,
  output logic [PSC_W-1:0]   psc_q,
  output logic [VAL_W-1:0]   lo_q,
  output logic [VAL_W-1:0]   hi_q
);
  logic [VAL_W-1:0] lo_pick, hi_pick;
  logic             capture;

  always_comb begin
    lo_pick = hs_sel ? lo_word[2*VAL_W-1:VAL_W] : lo_word[VAL_W-1:0];
    hi_pick = hs_sel ? hi_word[2*VAL_W-1:VAL_W] : hi_word[VAL_W-1:0];
    capture = !run || reload;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (capture) begin
      psc_q <= psc_in;
      lo_q  <= lo_pick;
      hi_q  <= hi_pick;
    end
  end

  // R5: captured setting holds through a running period
  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !reload) |=> ($stable(psc_q) && $stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
  parameter int unsigned PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             run,
  input  logic [PSC_W-1:0] div_val,
  output logic             tick
);
  logic [PSC_W-1:0] div_cnt;
  logic             wrap;

  assign wrap = (div_cnt == div_val);
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          div_cnt <= '0;
    else if (!enable)    div_cnt <= '0;
    else if (!run || wrap) div_cnt <= '0;
    else                 div_cnt <= div_cnt + 1'b1;
  end

  // R1: divider never runs past the captured prescale value
  a_r1_div_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (div_cnt <= div_val));
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr
  import scl_pkg::*;
#(
  parameter int unsigned VAL_W = 8,
  localparam int unsigned CNT_W = VAL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [VAL_W-1:0] lo_val,
  input  logic [VAL_W-1:0] hi_val,
  output scl_phase_e       phase,
  output logic             low_end,
  output logic             high_end
);
  localparam logic [CNT_W-1:0] LO_LAST_ADJ = CNT_W'(LOW_EXT - 1);
  localparam logic [CNT_W-1:0] HI_LAST_ADJ = CNT_W'(HIGH_EXT - 1);

  logic [CNT_W-1:0] tick_cnt;
  logic [CNT_W-1:0] lo_last, hi_last;
  logic             at_last;

  always_comb begin
    lo_last  = {1'b0, lo_val} + LO_LAST_ADJ;
    hi_last  = {1'b0, hi_val} + HI_LAST_ADJ;
    at_last  = (phase == PH_LOW) ? (tick_cnt == lo_last) : (tick_cnt == hi_last);
    low_end  = tick && at_last && (phase == PH_LOW);
    high_end = tick && at_last && (phase == PH_HIGH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_LOW;
      tick_cnt <= '0;
    end else if (!enable) begin
      phase    <= PH_LOW;
      tick_cnt <= '0;
    end else if (tick) begin
      if (at_last) begin
        phase    <= (phase == PH_LOW) ? PH_HIGH : PH_LOW;
        tick_cnt <= '0;
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  // R7: strobes are exclusive and only on a tick
  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_end && high_end));
  a_r7_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (low_end || high_end) |-> tick);
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
  import scl_pkg::*;
#(
  parameter int unsigned PSC_W = 8,
  parameter int unsigned VAL_W = 8,
  localparam int unsigned WORD_W = 2 * VAL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [PSC_W-1:0]  psc,
  input  logic [WORD_W-1:0] scl_lo_time,
  input  logic [WORD_W-1:0] scl_hi_time,
  input  logic              hs_mode,
  output logic              tick,
  output logic              scl,
  output logic              low_end,
  output logic              high_end
);
  logic             run_q;
  logic [PSC_W-1:0] psc_sh;
  logic [VAL_W-1:0] lo_sh, hi_sh;
  scl_phase_e       phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= enable;
  end

  scl_cfg_shadow #(.PSC_W(PSC_W), .VAL_W(VAL_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .run(run_q), .reload(high_end),
    .psc_in(psc), .lo_word(scl_lo_time), .hi_word(scl_hi_time), .hs_sel(hs_mode),
    .psc_q(psc_sh), .lo_q(lo_sh), .hi_q(hi_sh)
  );

  scl_tick_div #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .enable(enable), .run(run_q),
    .div_val(psc_sh), .tick(tick)
  );

  scl_phase_ctr #(.VAL_W(VAL_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .lo_val(lo_sh), .hi_val(hi_sh), .phase(phase),
    .low_end(low_end), .high_end(high_end)
  );

  assign scl = !run_q || (phase == PH_HIGH);

  // R6: disabled generator parks SCL high with no ticks
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (scl && !tick));
  // R7: end of low releases SCL; end of high pulls it low again
  a_r7_low_end_rise: assert property (@(posedge clk) disable iff (!rst_n)
    low_end |=> scl);
  a_r7_high_end_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (high_end && enable) |=> !scl);
endmodule

// File: tb/test_scl_rate_gen.sv
module test_scl_rate_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  psc = '0;
  logic [15:0] scl_lo_time = '0;
  logic [15:0] scl_hi_time = '0;
  logic        hs_mode = 1'b0;
  logic        tick, scl, low_end, high_end;

  logic [7:0]  n_psc;
  logic [15:0] n_lo, n_hi;
  logic        n_hs;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_rate_gen i_scl_rate_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .psc(psc),
    .scl_lo_time(scl_lo_time), .scl_hi_time(scl_hi_time), .hs_mode(hs_mode),
    .tick(tick), .scl(scl), .low_end(low_end), .high_end(high_end)
  );

  function automatic int sel_val(input logic [15:0] w, input logic hs);
    return hs ? int'(w[15:8]) : int'(w[7:0]);
  endfunction
  function automatic int low_ticks(input logic [15:0] w, input logic hs);
    return sel_val(w, hs) + 7;
  endfunction
  function automatic int high_ticks(input logic [15:0] w, input logic hs);
    return sel_val(w, hs) + 5;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
        summary();
      end
    end
  end

  task automatic apply_next();
    psc = n_psc; scl_lo_time = n_lo; scl_hi_time = n_hi; hs_mode = n_hs;
  endtask

  // Measure one phase at level lvl, starting at a negedge inside it.
  task automatic measure(input logic lvl, input int chg_at, output int len,
                         output int st_idx, output int st_cnt, output int tk_cnt,
                         output int bad_st);
    len = 0; st_idx = -1; st_cnt = 0; tk_cnt = 0; bad_st = 0;
    while (scl == lvl && len < 20000) begin
      if (lvl == 1'b0) begin
        if (low_end)  begin st_cnt++; st_idx = len; end
        if (high_end) bad_st++;
      end else begin
        if (high_end) begin st_cnt++; st_idx = len; end
        if (low_end)  bad_st++;
      end
      if (tick) tk_cnt++;
      if (len == chg_at) apply_next();
      len++;
      @(negedge clk);
    end
  endtask

  task automatic start_run(input logic [7:0] p, input logic [15:0] lo,
                           input logic [15:0] hi, input logic hs);
    @(negedge clk);
    enable = 1'b0;
    psc = p; scl_lo_time = lo; scl_hi_time = hi; hs_mode = hs;
    @(negedge clk);
    @(negedge clk);
    chk("R6 idle scl", int'(scl), 1);
    chk("R6 idle tick", int'(tick), 0);
    enable = 1'b1;
    @(negedge clk);
  endtask

  // Full period check with given settings; optional change in low or at high_end
  task automatic period_check(input logic [7:0] p, input logic [15:0] lo,
                              input logic [15:0] hi, input logic hs,
                              input int mode);
    int len, sidx, scnt, tcnt, bad;
    int lt, ht, nlt;
    lt = low_ticks(lo, hs);
    ht = high_ticks(hi, hs);
    start_run(p, lo, hi, hs);
    measure(1'b0, (mode == 1) ? 0 : -1, len, sidx, scnt, tcnt, bad);
    chk("R2 low cycles", len, lt * (int'(p) + 1));
    chk("R1 low ticks", tcnt, lt);
    chk("R7 low_end idx", sidx, len - 1);
    chk("R7 low_end count", scnt, 1);
    chk("R7 no high_end in low", bad, 0);
    measure(1'b1, (mode == 2) ? ht * (int'(p) + 1) - 1 : -1, len, sidx, scnt, tcnt, bad);
    chk("R3 high cycles", len, ht * (int'(p) + 1));
    chk("R1 high ticks", tcnt, ht);
    chk("R7 high_end idx", sidx, len - 1);
    chk("R7 high_end count", scnt, 1);
    chk("R7 no low_end in high", bad, 0);
    if (mode != 0) begin
      nlt = low_ticks(n_lo, n_hs);
      measure(1'b0, -1, len, sidx, scnt, tcnt, bad);
      chk("R5 next low uses new setting", len, nlt * (int'(n_psc) + 1));
      chk("R5 next low ticks", tcnt, nlt);
    end
  endtask

  initial begin
    int len, sidx, scnt, tcnt, bad;
    void'($urandom(32'd1729));
    repeat (3) @(negedge clk);
    chk("R6 reset scl", int'(scl), 1);
    chk("R6 reset tick", int'(tick), 0);
    chk("R7 reset strobes", int'(low_end) + int'(high_end), 0);
    rst_n = 1'b1;

    // Directed corners
    period_check(8'd0, 16'h0000, 16'h0000, 1'b0, 0);   // R1 psc 0, minimum phases
    period_check(8'd1, 16'h0005, 16'h0007, 1'b0, 0);   // R2 R3 fast setting
    period_check(8'd1, 16'h1705, 16'h1907, 1'b1, 0);   // R4 upper byte selected
    period_check(8'd2, 16'h1705, 16'h1907, 1'b0, 0);   // R4 lower byte selected

    // R5: change early in low phase -> only following low phase differs
    n_psc = 8'd3; n_lo = 16'h0009; n_hi = 16'h0002; n_hs = 1'b0;
    period_check(8'd1, 16'h0004, 16'h0003, 1'b0, 1);
    // R5: change in the high_end cycle -> next low phase uses it
    n_psc = 8'd0; n_lo = 16'h0C00; n_hi = 16'h0001; n_hs = 1'b1;
    period_check(8'd2, 16'h0002, 16'h0006, 1'b0, 2);

    // R6: disable in mid high phase, then restart with full low phase
    start_run(8'd1, 16'h0003, 16'h0004, 1'b0);
    measure(1'b0, -1, len, sidx, scnt, tcnt, bad);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk("R6 disable scl high", int'(scl), 1);
    chk("R6 disable no tick", int'(tick), 0);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    measure(1'b0, -1, len, sidx, scnt, tcnt, bad);
    chk("R6 restart full low", len, 10 * 2);

    // Constrained random settings
    for (int i = 0; i < 10; i++) begin
      logic [7:0]  rp;
      logic [15:0] rl, rh;
      logic        rs;
      rp = 8'($urandom % 4);
      rl = {8'($urandom % 40), 8'($urandom % 40)};
      rh = {8'($urandom % 40), 8'($urandom % 40)};
      rs = 1'($urandom % 2);
      n_psc = 8'($urandom % 3); n_lo = {8'($urandom % 20), 8'($urandom % 20)};
      n_hi = rh; n_hs = 1'($urandom % 2);
      period_check(rp, rl, rh, rs, int'($urandom % 3));
    end

    // One large setting
    period_check(8'd3, 16'h00FF, 16'hFF00, 1'b0, 0);

    summary();
  end
endmodule